// File: doc/BRIEF.md
# Elliptic Curve Point Step Datapath

This block performs one step of an elliptic-curve walk over a fixed 109-bit prime field. A host presents an input point (x, y) together with a precomputed field inverse and a path code, and the block runs a hard-wired sequence of modular additions, subtractions and multiplications. Two of the paths add one of two built-in base points to the input point. The third path doubles the input point. The block returns the y coordinate of the resulting point.

The inverse is computed outside the block: for an addition step it is the inverse of the x difference, and for doubling it is the inverse of 2y. The block does not check the inverse. It evaluates the formulas with whatever value it receives, so any operand values give a well-defined result. Multiplication is bit-serial. One multiply takes W+2 cycles, so a full step takes a few hundred cycles. The control is a small sequencer that walks a per-path list of micro-operations over three scratch registers.

Top module: `ecpd_top`

## Requirements
- R1: A request is accepted on a rising clock edge where `inValid` and `inReady` are both high. `inReady` is high only while the block is idle. It drops in the cycle after a valid request is accepted and stays low until the step finishes. `inValid` pulses and changes on the data inputs while `inReady` is low have no effect on the result.
- R2: Path code 0 adds the point (PX, PY), with PX = 0x4CC974EBBCBFDC3636FEB9F11C7 and PY = 0x7611B0EB1229C0BFC5F35521692. The steps are: lambda = (PY − y)·inv, then xn = lambda² − (x + PX), then result = lambda·(x − xn) − y.
- R3: Path code 1 uses the same sequence with the point (QX, QY), where QX = 0x233857E4E8B5F0055126E7D7B7C and QY = 0x19C8C91063EB4276371D68B6B4D9.
- R4: Path code 2 doubles the input point. The steps are: lambda = (3x² + A)·inv with A = 0xFD4C926FD178E9805E663021744, then xn = lambda² − 2x, then result = lambda·(x − xn) − y.
- R5: All arithmetic is modulo P = 0x1BD579792B380B5B521E6D9FB599, and every value the block presents on `result` is less than P.
- R6: `done` is high for exactly one cycle per completed step, in the cycle after the final subtraction is written. `result` changes only in that cycle and then holds its value until the next step completes.
- R7: Path code 3 is invalid. The block raises `err` for exactly one cycle, in the cycle after acceptance. It runs no operations, keeps `inReady` high, and leaves `done` low and `result` unchanged.
- R8: Operands at the field boundaries (0 and P−1 for x, y and inv) produce correctly reduced results on every path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block idle and able to accept a request |
| inPath | input | 2 | Path code: 0 = add point P, 1 = add point Q, 2 = double, 3 = invalid |
| inX | input | 109 | Input x coordinate, already reduced |
| inY | input | 109 | Input y coordinate, already reduced |
| inInv | input | 109 | Precomputed inverse, already reduced |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | One-cycle strobe for an invalid path code |
| result | output | 109 | Resulting y coordinate |

## Verification
Each of the three paths is driven with all-zero operands, all-one operands, operands at P−1, and a set of pseudo-random reduced operands. The bench compares each result with a wide-integer model that uses true multiplication and remainder.

- Zero and P−1 inputs drive the add and subtract steps across their wrap points. This exposes a missing or misplaced correction by P.
- Random inputs exercise every bit of the serial multiplier, and they separate the P and Q constants from each other.
- Garbage requests sent during a run, and invalid-code requests sent between runs, show whether anything other than an accepted valid request can disturb `result`.

// File: rtl/ecpd_pkg.sv
package ecpd_pkg;

  localparam logic [1:0] PATH_P   = 2'd0;
  localparam logic [1:0] PATH_Q   = 2'd1;
  localparam logic [1:0] PATH_DBL = 2'd2;
  localparam logic [1:0] PATH_BAD = 2'd3;

  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_MUL} opc_e;

  typedef enum logic [3:0] {
    S_X, S_Y, S_INV, S_T0, S_T1, S_T2, S_KX, S_KY, S_KA
  } src_e;

  typedef enum logic [1:0] {D_T0, D_T1, D_T2} dst_e;

  typedef struct packed {
    opc_e opc;
    src_e srcA;
    src_e srcB;
    dst_e dst;
    logic last;
  } uop_t;

  typedef struct packed {
    logic load;
    logic useQ;
    logic aluWr;
    logic mulStart;
    logic mulWr;
    logic finish;
    opc_e opc;
    src_e srcA;
    src_e srcB;
    dst_e dst;
  } ctrl_t;

endpackage

// File: rtl/ecpd_addsub.sv
module ecpd_addsub #(
  parameter int unsigned W = 109,
  parameter logic [W-1:0] P = '1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  logic [W:0] sum;
  logic [W:0] dif;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b};
    dif = {1'b0, a} - {1'b0, b};
    if (sub) begin
      // a borrow means the difference is negative, so fold it back by adding P
      y = dif[W] ? (dif[W-1:0] + P) : dif[W-1:0];
    end else begin
      y = (sum >= {1'b0, P}) ? (sum[W-1:0] - P) : sum[W-1:0];
    end
  end
endmodule

// File: rtl/ecpd_modmul.sv
module ecpd_modmul #(
  parameter int unsigned W = 109,
  parameter logic [W-1:0] P = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod,
  output logic         done
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  acc, aReg, bReg;
  logic [CW-1:0] cnt;
  logic          busy, doneR;
  logic [W-1:0]  dbl, addend, accNext;

  // each iteration: acc = 2*acc + bit*a (mod P), scanning b from its MSB
  assign addend = bReg[W-1] ? aReg : '0;

  ecpd_addsub #(.W(W), .P(P)) dbl_i (.a(acc), .b(acc),    .sub(1'b0), .y(dbl));
  ecpd_addsub #(.W(W), .P(P)) acc_i (.a(dbl), .b(addend), .sub(1'b0), .y(accNext));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      aReg  <= '0;
      bReg  <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (start) begin
        acc  <= '0;
        aReg <= a;
        bReg <= b;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        acc  <= accNext;
        bReg <= bReg << 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy  <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;
  assign done = doneR;
endmodule

// File: rtl/ecpd_control.sv
module ecpd_control
  import ecpd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inPath,
  input  logic       mulDone,
  output logic       inReady,
  output ctrl_t      ctrl,
  output logic       done,
  output logic       err
);
  localparam int unsigned SW = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_MULW} state_e;

  state_e        state;
  logic [1:0]    pathR;
  logic [SW-1:0] step;
  logic          doneR, errR;
  uop_t          cur;

  function automatic uop_t mk(opc_e o, src_e sa, src_e sb, dst_e d, logic l);
    uop_t u;
    u.opc = o; u.srcA = sa; u.srcB = sb; u.dst = d; u.last = l;
    return u;
  endfunction

  function automatic uop_t fetch(logic [1:0] pth, logic [SW-1:0] stp);
    uop_t u;
    u = mk(OP_ADD, S_X, S_X, D_T2, 1'b1);
    if (pth == PATH_DBL) begin
      case (stp)
        SW'(0):  u = mk(OP_MUL, S_X,  S_X,   D_T0, 1'b0); // x^2
        SW'(1):  u = mk(OP_ADD, S_T0, S_T0,  D_T1, 1'b0); // 2x^2
        SW'(2):  u = mk(OP_ADD, S_T1, S_T0,  D_T1, 1'b0); // 3x^2
        SW'(3):  u = mk(OP_ADD, S_T1, S_KA,  D_T1, 1'b0); // 3x^2 + A
        SW'(4):  u = mk(OP_MUL, S_T1, S_INV, D_T0, 1'b0); // lambda
        SW'(5):  u = mk(OP_ADD, S_X,  S_X,   D_T1, 1'b0); // 2x
        SW'(6):  u = mk(OP_MUL, S_T0, S_T0,  D_T2, 1'b0); // lambda^2
        SW'(7):  u = mk(OP_SUB, S_T2, S_T1,  D_T2, 1'b0); // xn
        SW'(8):  u = mk(OP_SUB, S_X,  S_T2,  D_T1, 1'b0); // x - xn
        SW'(9):  u = mk(OP_MUL, S_T0, S_T1,  D_T1, 1'b0);
        default: u = mk(OP_SUB, S_T1, S_Y,   D_T1, 1'b1); // final y
      endcase
    end else begin
      case (stp)
        SW'(0):  u = mk(OP_SUB, S_KY, S_Y,   D_T0, 1'b0); // Ky - y
        SW'(1):  u = mk(OP_MUL, S_T0, S_INV, D_T0, 1'b0); // lambda
        SW'(2):  u = mk(OP_ADD, S_X,  S_KX,  D_T1, 1'b0); // x + Kx
        SW'(3):  u = mk(OP_MUL, S_T0, S_T0,  D_T2, 1'b0); // lambda^2
        SW'(4):  u = mk(OP_SUB, S_T2, S_T1,  D_T2, 1'b0); // xn
        SW'(5):  u = mk(OP_SUB, S_X,  S_T2,  D_T1, 1'b0); // x - xn
        SW'(6):  u = mk(OP_MUL, S_T0, S_T1,  D_T1, 1'b0);
        default: u = mk(OP_SUB, S_T1, S_Y,   D_T1, 1'b1); // final y
      endcase
    end
    return u;
  endfunction

  assign cur     = fetch(pathR, step);
  assign inReady = (state == ST_IDLE);

  always_comb begin
    ctrl          = '0;
    ctrl.opc      = cur.opc;
    ctrl.srcA     = cur.srcA;
    ctrl.srcB     = cur.srcB;
    ctrl.dst      = cur.dst;
    ctrl.useQ     = (pathR == PATH_Q);
    unique case (state)
      ST_IDLE: ctrl.load = inValid && (inPath != PATH_BAD);
      ST_EXEC: begin
        if (cur.opc == OP_MUL) begin
          ctrl.mulStart = 1'b1;
        end else begin
          ctrl.aluWr  = 1'b1;
          ctrl.finish = cur.last;
        end
      end
      ST_MULW: ctrl.mulWr = mulDone;
      default: ctrl.load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pathR <= PATH_P;
      step  <= '0;
      doneR <= 1'b0;
      errR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      errR  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (inValid) begin
            if (inPath == PATH_BAD) begin
              errR <= 1'b1;
            end else begin
              pathR <= inPath;
              step  <= '0;
              state <= ST_EXEC;
            end
          end
        end
        ST_EXEC: begin
          if (cur.opc == OP_MUL) begin
            state <= ST_MULW;
          end else if (cur.last) begin
            doneR <= 1'b1;
            state <= ST_IDLE;
          end else begin
            step <= step + 1'b1;
          end
        end
        ST_MULW: begin
          if (mulDone) begin
            step  <= step + 1'b1;
            state <= ST_EXEC;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done = doneR;
  assign err  = errR;
endmodule

// File: rtl/ecpd_datapath.sv
module ecpd_datapath
  import ecpd_pkg::*;
#(
  parameter int unsigned W = 109,
  parameter logic [W-1:0] P  = '1,
  parameter logic [W-1:0] PX = '0,
  parameter logic [W-1:0] PY = '0,
  parameter logic [W-1:0] QX = '0,
  parameter logic [W-1:0] QY = '0,
  parameter logic [W-1:0] CA = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_t        ctrl,
  input  logic [W-1:0] inX,
  input  logic [W-1:0] inY,
  input  logic [W-1:0] inInv,
  output logic         mulDone,
  output logic [W-1:0] result
);
  logic [W-1:0] rX, rY, rInv, t0, t1, t2, res;
  logic [W-1:0] opA, opB, aluY, mulP, wVal;

  function automatic logic [W-1:0] pick(src_e s, logic useQ,
      logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] inv,
      logic [W-1:0] a0, logic [W-1:0] a1, logic [W-1:0] a2);
    logic [W-1:0] v;
    case (s)
      S_X:     v = x;
      S_Y:     v = y;
      S_INV:   v = inv;
      S_T0:    v = a0;
      S_T1:    v = a1;
      S_T2:    v = a2;
      S_KX:    v = useQ ? QX : PX;
      S_KY:    v = useQ ? QY : PY;
      S_KA:    v = CA;
      default: v = '0;
    endcase
    return v;
  endfunction

  assign opA = pick(ctrl.srcA, ctrl.useQ, rX, rY, rInv, t0, t1, t2);
  assign opB = pick(ctrl.srcB, ctrl.useQ, rX, rY, rInv, t0, t1, t2);

  ecpd_addsub #(.W(W), .P(P)) alu_i (
    .a(opA), .b(opB), .sub(ctrl.opc == OP_SUB), .y(aluY)
  );

  ecpd_modmul #(.W(W), .P(P)) mul_i (
    .clk(clk), .rstN(rstN), .start(ctrl.mulStart),
    .a(opA), .b(opB), .prod(mulP), .done(mulDone)
  );

  assign wVal = ctrl.mulWr ? mulP : aluY;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rX   <= '0;
      rY   <= '0;
      rInv <= '0;
      t0   <= '0;
      t1   <= '0;
      t2   <= '0;
      res  <= '0;
    end else begin
      if (ctrl.load) begin
        rX   <= inX;
        rY   <= inY;
        rInv <= inInv;
      end
      if (ctrl.aluWr || ctrl.mulWr) begin
        case (ctrl.dst)
          D_T0:    t0 <= wVal;
          D_T1:    t1 <= wVal;
          default: t2 <= wVal;
        endcase
      end
      if (ctrl.finish) res <= aluY;
    end
  end

  assign result = res;
endmodule

// File: rtl/ecpd_top.sv
module ecpd_top
  import ecpd_pkg::*;
#(
  parameter int unsigned W = 109,
  parameter logic [W-1:0] P  = 109'h1BD579792B380B5B521E6D9FB599,
  parameter logic [W-1:0] PX = 109'h4CC974EBBCBFDC3636FEB9F11C7,
  parameter logic [W-1:0] PY = 109'h7611B0EB1229C0BFC5F35521692,
  parameter logic [W-1:0] QX = 109'h233857E4E8B5F0055126E7D7B7C,
  parameter logic [W-1:0] QY = 109'h19C8C91063EB4276371D68B6B4D9,
  parameter logic [W-1:0] CA = 109'hFD4C926FD178E9805E663021744
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  input  logic [1:0]   inPath,
  input  logic [W-1:0] inX,
  input  logic [W-1:0] inY,
  input  logic [W-1:0] inInv,
  output logic         done,
  output logic         err,
  output logic [W-1:0] result
);
  ctrl_t ctrl;
  logic  mulDone;

  ecpd_control ctl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPath(inPath),
    .mulDone(mulDone), .inReady(inReady), .ctrl(ctrl), .done(done), .err(err)
  );

  ecpd_datapath #(
    .W(W), .P(P), .PX(PX), .PY(PY), .QX(QX), .QY(QY), .CA(CA)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inX(inX), .inY(inY),
    .inInv(inInv), .mulDone(mulDone), .result(result)
  );
endmodule

// File: rtl/ecpd_checker.sv
module ecpd_checker #(
  parameter int unsigned W = 109,
  parameter logic [W-1:0] P = '1
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         inReady,
  input logic [1:0]   inPath,
  input logic         done,
  input logic         err,
  input logic [W-1:0] result
);
  // R1: an accepted valid request makes the block busy
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inPath != 2'd3) |=> !inReady);

  // R5: presented results are reduced
  p_result_reduced_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result < P));

  // R6: done lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: result moves only together with done
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  // R7: invalid path code gives an error pulse and no run
  p_bad_path_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inPath == 2'd3) |=> (err && inReady && !done));

  // R7: err has no other cause
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $past(inValid && inReady && inPath == 2'd3));
endmodule

bind ecpd_top ecpd_checker #(.W(W), .P(P)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inPath(inPath), .done(done), .err(err), .result(result)
);

// File: tb/ecpd_top_tb_top.sv
`timescale 1ns/1ps
module ecpd_top_tb_top;
  localparam int W = 109;
  localparam logic [W-1:0] P  = 109'h1BD579792B380B5B521E6D9FB599;
  localparam logic [W-1:0] PX = 109'h4CC974EBBCBFDC3636FEB9F11C7;
  localparam logic [W-1:0] PY = 109'h7611B0EB1229C0BFC5F35521692;
  localparam logic [W-1:0] QX = 109'h233857E4E8B5F0055126E7D7B7C;
  localparam logic [W-1:0] QY = 109'h19C8C91063EB4276371D68B6B4D9;
  localparam logic [W-1:0] CA = 109'hFD4C926FD178E9805E663021744;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inPath = 2'd0;
  logic [W-1:0] inX = '0, inY = '0, inInv = '0;
  logic inReady, done, err;
  logic [W-1:0] result;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ecpd_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inPath(inPath), .inX(inX), .inY(inY), .inInv(inInv),
    .done(done), .err(err), .result(result)
  );

  function automatic logic [W-1:0] fAdd(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, P}) s = s - {1'b0, P};
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] fSub(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    if (a >= b) s = {1'b0, a} - {1'b0, b};
    else        s = {1'b0, a} + {1'b0, P} - {1'b0, b};
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] fMul(logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-1:0] t;
    t = (2*W)'(a) * (2*W)'(b);
    t = t % (2*W)'(P);
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] model(logic [1:0] pth, logic [W-1:0] x,
                                         logic [W-1:0] y, logic [W-1:0] inv);
    logic [W-1:0] lam, xn, kx, ky;
    if (pth == 2'd2) begin
      lam = fMul(fAdd(fAdd(fMul(x, x), fMul(x, x)), fAdd(fMul(x, x), CA)), inv);
      xn  = fSub(fMul(lam, lam), fAdd(x, x));
    end else begin
      kx  = (pth == 2'd1) ? QX : PX;
      ky  = (pth == 2'd1) ? QY : PY;
      lam = fMul(fSub(ky, y), inv);
      xn  = fSub(fMul(lam, lam), fAdd(x, kx));
    end
    return fSub(fMul(lam, fSub(x, xn)), y);
  endfunction

  function automatic logic [W-1:0] rnd();
    logic [127:0] r;
    r = {$urandom, $urandom, $urandom, $urandom};
    r = r % 128'(P);
    return r[W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic runStep(input logic [1:0] pth, input logic [W-1:0] x,
                         input logic [W-1:0] y, input logic [W-1:0] inv,
                         input string req);
    logic [W-1:0] exp, got;
    int waitCnt;
    exp = model(pth, x, y, inv);
    @(negedge clk);
    inValid = 1'b1; inPath = pth; inX = x; inY = y; inInv = inv;
    @(negedge clk);
    check(inReady == 1'b0, "R1 busy after accept", W'(inReady), W'(0));
    // garbage request while busy must be ignored (R1)
    inX = rnd(); inY = rnd(); inInv = rnd(); inPath = 2'd2;
    @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    waitCnt = 0;
    while (!done && waitCnt < 3000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done == 1'b1, {req, " done seen"}, W'(done), W'(1));
    got = result;
    check(got == exp, req, got, exp);
    check(got < P, "R5 reduced", got, P);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", W'(done), W'(0));
    check(result == got, "R6 result held", result, got);
    check(inReady == 1'b1, "R1 ready after done", W'(inReady), W'(1));
  endtask

  task automatic badPath();
    logic [W-1:0] prev;
    prev = result;
    @(negedge clk);
    inValid = 1'b1; inPath = 2'd3; inX = rnd(); inY = rnd(); inInv = rnd();
    @(negedge clk);
    inValid = 1'b0;
    check(err == 1'b1, "R7 err raised", W'(err), W'(1));
    check(inReady == 1'b1, "R7 stays ready", W'(inReady), W'(1));
    check(done == 1'b0, "R7 no done", W'(done), W'(0));
    @(negedge clk);
    check(err == 1'b0, "R7 err one cycle", W'(err), W'(0));
    check(result == prev, "R7 result unchanged", result, prev);
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R7 no run started", W'(done), W'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(inReady == 1'b1, "reset inReady", W'(inReady), W'(1));
    check(done == 1'b0, "reset done", W'(done), W'(0));
    check(err == 1'b0, "reset err", W'(err), W'(0));
    check(result == '0, "reset result", result, '0);
    rstN = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 3; p++) begin
      string tag;
      tag = (p == 0) ? "R2 path P" : (p == 1) ? "R3 path Q" : "R4 double";
      runStep(2'(p), '0, '0, '0, {tag, " R8 zeros"});
      runStep(2'(p), P - 1'b1, P - 1'b1, P - 1'b1, {tag, " R8 max"});
      runStep(2'(p), W'(1), W'(1), W'(1), {tag, " ones"});
      runStep(2'(p), '0, P - 1'b1, W'(1), {tag, " R8 mixed"});
      badPath();
      for (int i = 0; i < 8; i++) begin
        runStep(2'(p), rnd(), rnd(), rnd(), {tag, " random"});
      end
    end
    badPath();
    summary();
  end
endmodule